// File: doc/BRIEF.md
# LIN Break Timer and Sync Field Detector

This block sits between a single-wire bus transceiver and a UART. It measures each low pulse on the bus with a free-running break timer: the timer clears and starts on a falling edge, and it holds its value on the next rising edge. Software can then read the held count and classify the pulse as a break, a sync pulse, or a short or long data bit on a bit-serial diagnostic bus. The timer is compared against a value written by software. It reports a match, an overflow when the bus stays low too long, and, if enabled, every rising edge. These are sticky status bits that are cleared by writing one, and each is routed to a single maskable interrupt line.

In LIN operation, a low pulse at least as long as the compare value is taken as a break. The next falling edge (the start bit of the sync byte) starts a sync timer. That timer stops on a programmable count of rising or falling edges. When receive gating is enabled, the UART receive line is held high from reset, and again from each accepted break, until the sync timer has stopped. This means the UART never sees the break or the sync byte. A standalone test setting routes two external pins to the transceiver side and bypasses the UART.

Software reaches the block through a small register port with write enable, a 3-bit address, 16-bit write data, and read data that is registered one cycle after the address.

Top module: `lin_break_sync`

## Requirements
- R1: The control register (address 0) is 16 bits wide and resets to 0. Bits 15..13 always read 0 and ignore writes. Bits 12..0 read back what was written.
- R2: Control bit 0 selects the protocol: 0 for LIN, 1 for diagnostic bus. While it is 1, the break/sync detector stays idle, so status bits 3 and 4 read 0, and with gating on the UART receive output stays high.
- R3: The break timer (read at address 2) clears on a synchronized falling edge of `bus_rx`, counts once per clock while the bus is low, and holds on the rising edge. A low pulse of L clocks reads back as L-1.
- R4: With control bit 6 set, each rising edge on the bus sets status bit 0 (address 3). With bit 6 clear, status bit 0 is not set, and bit 6 also enables that status bit toward `irq`.
- R5: Status bit 1 is set when the running timer equals the compare value (written at address 2 through its low TW bits). Control bit 4 set to 1 removes status bit 1 from `irq`.
- R6: If the timer reaches its maximum, 2^TW-1, while the bus is still low, status bit 2 is set and the timer stops at that value. Control bit 5 set to 1 removes status bit 2 from `irq`.
- R7: With control bit 2 set, `uart_rx` is held at 1 until a break and the sync byte after it have been detected. After that, and always when bit 2 is clear, `uart_rx` follows `bus_rx` three clocks later.
- R8: The sync timer (read at address 4) starts on the first falling edge after a break. It counts one per clock and stops on the Nth counted edge, where N is bits 3..0 of address 1 (0 means 16). Control bit 1 selects which edges are counted: 1 counts rising edges, 0 counts falling edges. Status bit 3 reads 1 once the timer has stopped, and status bit 4 reads 1 from break acceptance until then.
- R9: In LIN mode, a break is accepted on the rising edge that ends a low pulse whose held count is at least the compare value. Shorter pulses are not accepted. Each accepted break closes the receive gate again.
- R10: With control bit 3 set, `xcvr_txd` follows `test_txd`, `test_rxd` follows `bus_rx`, and `uart_rx` is held at 1. With bit 3 clear, `xcvr_txd` follows `uart_txd` and `test_rxd` is 1. Each of these outputs is registered with one clock of delay.
- R11: Writing 1s to status bits 2..0 at address 3 clears them, but a new event in the same cycle takes priority. `irq` is registered and equals the OR of the enabled status bits from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data for `addr` |
| bus_rx | input | 1 | Receive level from the bus transceiver |
| uart_rx | output | 1 | Gated receive line to the UART |
| uart_txd | input | 1 | Transmit data from the UART |
| test_txd | input | 1 | External pin driving the transceiver in test mode |
| test_rxd | output | 1 | External pin showing bus receive in test mode |
| xcvr_txd | output | 1 | Transmit line to the transceiver |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a completed sync field. To get there, the bench must first produce a low pulse that passes the compare threshold, then a correctly shaped sync byte whose edge count meets the selected polarity and N exactly. It must then do the same again to show that the gate closes and reopens. The bench drives real break, delimiter and 0x55 byte waveforms at 16 clocks per bit. It runs the block with a 10-bit timer so that overflow can be reached in about a thousand cycles. A behavioural model is compared against every output on every clock, and directed reads check the hand-computed sync times (127 clocks for four falling edges, 143 for five rising edges).

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [1:0] {SY_IDLE, SY_BRK, SY_MEAS, SY_DONE} sy_state_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_TMR  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_SYNC = 3'd4;

  localparam int C_MODE   = 0;
  localparam int C_POL    = 1;
  localparam int C_GATE   = 2;
  localparam int C_TEST   = 3;
  localparam int C_CMPDIS = 4;
  localparam int C_OVFDIS = 5;
  localparam int C_RISEEN = 6;

  localparam logic [15:0] CTRL_WMASK = 16'h1FFF;
endpackage

// File: rtl/lbs_edge.sv
module lbs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/lbs_break_timer.sv
module lbs_break_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          rise,
  input  logic [TW-1:0] cmp,
  output logic [TW-1:0] cnt,
  output logic          run,
  output logic          cmp_ev,
  output logic          ovf_ev,
  output logic          brk_ev
);
  localparam logic [TW-1:0] MAXV = '1;

  assign cmp_ev = run && (cnt == cmp);
  assign ovf_ev = run && !rise && (cnt == MAXV);
  assign brk_ev = run && rise && (cnt >= cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (fall) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (rise || cnt == MAXV) run <= 1'b0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  // R3: an idle timer keeps its captured value
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !fall) |=> $stable(cnt));
  // R6: overflow stops the timer at its maximum
  p_ovf_stop_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> (!run && cnt == MAXV));
endmodule

// File: rtl/lbs_sync_fsm.sv
module lbs_sync_fsm
  import lbs_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lin_mode,
  input  logic          pol,
  input  logic [3:0]    nsel,
  input  logic          rise,
  input  logic          fall,
  input  logic          brk_ev,
  output sy_state_t     state,
  output logic [SW-1:0] scnt
);
  localparam logic [SW-1:0] SMAX = '1;

  logic [4:0] ecnt;
  logic [4:0] target;
  logic       sel_edge;

  assign target   = (nsel == 4'd0) ? 5'd16 : {1'b0, nsel};
  assign sel_edge = pol ? rise : fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SY_IDLE;
      scnt  <= '0;
      ecnt  <= '0;
    end else if (!lin_mode) begin
      state <= SY_IDLE;
    end else if (brk_ev) begin
      state <= SY_BRK;
      scnt  <= '0;
      ecnt  <= '0;
    end else begin
      case (state)
        SY_BRK: if (fall) begin
          state <= SY_MEAS;
          scnt  <= '0;
          ecnt  <= '0;
        end
        SY_MEAS: begin
          if (sel_edge && (ecnt + 5'd1 == target)) begin
            state <= SY_DONE;
          end else begin
            if (sel_edge)      ecnt <= ecnt + 5'd1;
            if (scnt != SMAX)  scnt <= scnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: completion is only reached from an active measurement
  p_done_from_meas_r8: assert property (@(posedge clk) disable iff (rst)
    (state == SY_DONE && $past(state) != SY_DONE) |-> $past(state) == SY_MEAS);
  // R2: diagnostic mode parks the detector
  p_diag_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !lin_mode |=> state == SY_IDLE);
endmodule

// File: rtl/lin_break_sync.sv
module lin_break_sync
  import lbs_pkg::*;
#(
  parameter int TW     = 16,
  parameter int SW     = 16,
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        bus_rx,
  output logic        uart_rx,
  input  logic        uart_txd,
  input  logic        test_txd,
  output logic        test_rxd,
  output logic        xcvr_txd,
  output logic        irq
);
  logic [15:0]   ctrl;
  logic [3:0]    cfg;
  logic [TW-1:0] cmp;
  logic [2:0]    stat;
  logic          lvl, rise, fall;
  logic [TW-1:0] tcnt;
  logic          trun, cmp_ev, ovf_ev, brk_ev;
  sy_state_t     st;
  logic [SW-1:0] scnt;
  logic [2:0]    clr, set, mask;
  logic          wr_stat;

  lbs_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(bus_rx), .lvl(lvl), .rise(rise), .fall(fall));

  lbs_break_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise), .cmp(cmp),
    .cnt(tcnt), .run(trun), .cmp_ev(cmp_ev), .ovf_ev(ovf_ev), .brk_ev(brk_ev));

  lbs_sync_fsm #(.SW(SW)) u_sync (
    .clk(clk), .rst(rst), .lin_mode(!ctrl[C_MODE]), .pol(ctrl[C_POL]),
    .nsel(cfg), .rise(rise), .fall(fall), .brk_ev(brk_ev),
    .state(st), .scnt(scnt));

  assign wr_stat = wr_en && (addr == A_STAT);
  assign clr  = wr_stat ? wdata[2:0] : 3'b000;
  assign set  = {ovf_ev, cmp_ev, rise & ctrl[C_RISEEN]};
  assign mask = {~ctrl[C_OVFDIS], ~ctrl[C_CMPDIS], ctrl[C_RISEEN]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      cfg  <= '0;
      cmp  <= '0;
      stat <= '0;
    end else begin
      stat <= (stat & ~clr) | set;
      if (wr_en) begin
        case (addr)
          A_CTRL: ctrl <= wdata & CTRL_WMASK;
          A_CFG:  cfg  <= wdata[3:0];
          A_TMR:  cmp  <= wdata[TW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      irq      <= 1'b0;
      uart_rx  <= 1'b1;
      xcvr_txd <= 1'b1;
      test_rxd <= 1'b1;
    end else begin
      irq      <= |(stat & mask);
      uart_rx  <= ctrl[C_TEST] ? 1'b1 :
                  (ctrl[C_GATE] && st != SY_DONE) ? 1'b1 : lvl;
      xcvr_txd <= ctrl[C_TEST] ? test_txd : uart_txd;
      test_rxd <= ctrl[C_TEST] ? bus_rx : 1'b1;
      case (addr)
        A_CTRL:  rdata <= ctrl;
        A_CFG:   rdata <= {12'h000, cfg};
        A_TMR:   rdata <= 16'(tcnt);
        A_STAT:  rdata <= {11'h000, (st == SY_BRK || st == SY_MEAS),
                           (st == SY_DONE), stat};
        A_SYNC:  rdata <= 16'(scnt);
        default: rdata <= '0;
      endcase
    end
  end

  // R7: gate closed means the UART sees idle
  p_gate_high_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl[C_GATE] && st != SY_DONE) |=> uart_rx);
  // R11: no pending status, no interrupt next cycle
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (stat == 3'b000) |=> !irq);
  // R10: test pin idles high outside test mode
  p_test_rx_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl[C_TEST] |=> test_rxd);
  // R4: rising-edge status cannot appear while its enable is off
  p_rise_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[C_RISEEN] && !stat[0]) |=> !stat[0]);
endmodule

// File: tb/test_lin_break_sync.sv
module test_lin_break_sync;
  localparam int TW = 10;
  localparam int SW = 16;
  localparam int TMAX = (1 << TW) - 1;
  localparam int SMAX = (1 << SW) - 1;
  localparam int BT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        bus_rx = 1'b1;
  logic        uart_rx;
  logic        uart_txd = 1'b1;
  logic        test_txd = 1'b1;
  logic        test_rxd;
  logic        xcvr_txd;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_break_sync #(.TW(TW), .SW(SW)) i_lin_break_sync (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bus_rx(bus_rx), .uart_rx(uart_rx), .uart_txd(uart_txd),
    .test_txd(test_txd), .test_rxd(test_rxd), .xcvr_txd(xcvr_txd), .irq(irq));

  // ---------------- behavioural reference model ----------------
  logic        hist[$] = '{1'b1, 1'b1, 1'b1};
  logic [15:0] m_ctrl;
  int          m_cfg, m_cmp, m_stat, m_tcnt, m_scnt, m_ecnt, m_phase;
  bit          m_trun;
  logic [15:0] m_rdata = '0;
  logic        m_irq = 1'b0, m_urx = 1'b1, m_xtx = 1'b1, m_trx = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{1'b1, 1'b1, 1'b1};
      m_ctrl = '0; m_cfg = 0; m_cmp = 0; m_stat = 0;
      m_tcnt = 0; m_trun = 0; m_scnt = 0; m_ecnt = 0; m_phase = 0;
      m_rdata = '0; m_irq = 0; m_urx = 1; m_xtx = 1; m_trx = 1;
    end else begin
      logic lv, pv, r, f, ce, oe, be, se;
      int msk, tgt, clr;
      lv = hist[1]; pv = hist[2];
      r = lv & ~pv; f = ~lv & pv;
      msk = (m_ctrl[5] ? 0 : 4) | (m_ctrl[4] ? 0 : 2) | (m_ctrl[6] ? 1 : 0);
      m_irq = (m_stat & msk) != 0;
      m_urx = m_ctrl[3] ? 1'b1 : ((m_ctrl[2] && m_phase != 3) ? 1'b1 : lv);
      m_xtx = m_ctrl[3] ? test_txd : uart_txd;
      m_trx = m_ctrl[3] ? bus_rx : 1'b1;
      case (addr)
        3'd0: m_rdata = m_ctrl;
        3'd1: m_rdata = 16'(m_cfg);
        3'd2: m_rdata = 16'(m_tcnt);
        3'd3: m_rdata = 16'(m_stat + ((m_phase == 3) ? 8 : 0) +
                            ((m_phase == 1 || m_phase == 2) ? 16 : 0));
        3'd4: m_rdata = 16'(m_scnt);
        default: m_rdata = '0;
      endcase
      ce = m_trun && m_tcnt == m_cmp;
      oe = m_trun && !r && m_tcnt == TMAX;
      be = m_trun && r && m_tcnt >= m_cmp;
      // sync detector
      if (m_ctrl[0]) m_phase = 0;
      else if (be) begin m_phase = 1; m_scnt = 0; m_ecnt = 0; end
      else if (m_phase == 1) begin
        if (f) begin m_phase = 2; m_scnt = 0; m_ecnt = 0; end
      end else if (m_phase == 2) begin
        se = m_ctrl[1] ? r : f;
        tgt = (m_cfg == 0) ? 16 : m_cfg;
        if (se && m_ecnt + 1 == tgt) m_phase = 3;
        else begin
          if (se) m_ecnt++;
          if (m_scnt != SMAX) m_scnt++;
        end
      end
      // break timer
      if (f) begin m_tcnt = 0; m_trun = 1; end
      else if (m_trun) begin
        if (r || m_tcnt == TMAX) m_trun = 0;
        else m_tcnt++;
      end
      // status and registers
      clr = (wr_en && addr == 3'd3) ? int'(wdata[2:0]) : 0;
      m_stat = (m_stat & ~clr) | (oe ? 4 : 0) | (ce ? 2 : 0) | ((r && m_ctrl[6]) ? 1 : 0);
      if (wr_en) begin
        case (addr)
          3'd0: m_ctrl = wdata & 16'h1FFF;
          3'd1: m_cfg = int'(wdata[3:0]);
          3'd2: m_cmp = int'(wdata[TW-1:0]);
          default: ;
        endcase
      end
      hist.push_front(bus_rx);
      void'(hist.pop_back());
    end
  end

  function automatic string rd_tag(logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R8";
      3'd2: return "R3";
      3'd3: return "R11";
      3'd4: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic cmp1(string tag, string nm, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, nm, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp1(rd_tag(addr), "rdata", rdata, m_rdata);
      cmp1("R7", "uart_rx", 16'(uart_rx), 16'(m_urx));
      cmp1("R11", "irq", 16'(irq), 16'(m_irq));
      cmp1("R10", "xcvr_txd", 16'(xcvr_txd), 16'(m_xtx));
      cmp1("R10", "test_rxd", 16'(test_rxd), 16'(m_trx));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic set_bus(logic v, int n);
    bus_rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b);
    set_bus(1'b0, BT);
    for (int i = 0; i < 8; i++) set_bus(b[i], BT);
    set_bus(1'b1, BT);
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    cmp1(tag, "directed", got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state and reserved bits
    rd(3'd0, v); chk("R1", v, 16'h0000);
    rd(3'd3, v); chk("R11", v, 16'h0000);
    chk("R11", 16'(irq), 16'h0);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); chk("R1", v, 16'h1FFF);
    wr(3'd0, 16'h0000);
    // R3 pulse width capture, R4 masked rising edge
    wr(3'd2, 16'd100);
    set_bus(1'b0, 40); set_bus(1'b1, 6);
    rd(3'd2, v); chk("R3", v, 16'd39);
    rd(3'd3, v); chk("R4", v, 16'h0000);
    // R4 rising edge status and interrupt, R11 clear
    wr(3'd0, 16'h0040);
    set_bus(1'b0, 30); set_bus(1'b1, 6);
    rd(3'd3, v); chk("R4", v & 16'h1, 16'h1);
    chk("R11", 16'(irq), 16'h1);
    wr(3'd3, 16'h0001); idle(2);
    rd(3'd3, v); chk("R11", v, 16'h0000);
    chk("R11", 16'(irq), 16'h0);
    // R5 compare match with interrupt enabled then disabled
    wr(3'd0, 16'h0000); wr(3'd2, 16'd20);
    set_bus(1'b0, 50); set_bus(1'b1, 6);
    rd(3'd3, v); chk("R5", v & 16'h2, 16'h2);
    chk("R5", 16'(irq), 16'h1);
    wr(3'd3, 16'h0007);
    wr(3'd0, 16'h0010);
    set_bus(1'b0, 50); set_bus(1'b1, 6);
    rd(3'd3, v); chk("R5", v & 16'h2, 16'h2);
    chk("R5", 16'(irq), 16'h0);
    wr(3'd3, 16'h0007);
    // R6 overflow
    wr(3'd0, 16'h0030);
    set_bus(1'b0, 1100); set_bus(1'b1, 6);
    rd(3'd2, v); chk("R6", v, 16'(TMAX));
    rd(3'd3, v); chk("R6", v & 16'h4, 16'h4);
    chk("R6", 16'(irq), 16'h0);
    wr(3'd0, 16'h0010); idle(2);
    chk("R6", 16'(irq), 16'h1);
    wr(3'd3, 16'h0007);
    // R7/R8/R9 LIN frame, gate on, 4 falling edges
    wr(3'd0, 16'h0004); wr(3'd1, 16'h0004); wr(3'd2, 16'd150);
    set_bus(1'b0, 100);
    chk("R7", 16'(uart_rx), 16'h1);
    set_bus(1'b0, 108); set_bus(1'b1, BT);
    send_byte(8'h55); idle(4);
    rd(3'd3, v); chk("R8", v & 16'h18, 16'h08);
    rd(3'd4, v); chk("R8", v, 16'd127);
    set_bus(1'b0, 10); chk("R7", 16'(uart_rx), 16'h0);
    set_bus(1'b1, 10); chk("R7", 16'(uart_rx), 16'h1);
    // R8 rising polarity, 5 edges; R9 gate closes again on new break
    wr(3'd0, 16'h0006); wr(3'd1, 16'h0005);
    set_bus(1'b0, 208); set_bus(1'b1, BT);
    set_bus(1'b0, 8); chk("R9", 16'(uart_rx), 16'h1);
    rd(3'd3, v); chk("R9", v & 16'h18, 16'h10);
    set_bus(1'b0, 7);
    for (int i = 0; i < 8; i++) set_bus(i[0] ? 1'b0 : 1'b1, BT);
    set_bus(1'b1, BT); idle(4);
    rd(3'd4, v); chk("R8", v, 16'd143);
    rd(3'd3, v); chk("R8", v & 16'h18, 16'h08);
    // R9 short low pulse is not a break
    wr(3'd0, 16'h0007); idle(2); wr(3'd0, 16'h0006);
    set_bus(1'b0, 100); set_bus(1'b1, BT);
    send_byte(8'h55); idle(4);
    rd(3'd3, v); chk("R9", v & 16'h18, 16'h00);
    // R2 diagnostic mode keeps detector idle and gate shut
    wr(3'd0, 16'h0005);
    set_bus(1'b0, 208); set_bus(1'b1, BT);
    send_byte(8'h55);
    set_bus(1'b0, 10); chk("R2", 16'(uart_rx), 16'h1);
    set_bus(1'b1, 4);
    rd(3'd3, v); chk("R2", v & 16'h18, 16'h00);
    // R10 standalone test routing
    wr(3'd0, 16'h0008);
    uart_txd = 1'b0; test_txd = 1'b1; idle(2);
    chk("R10", 16'(xcvr_txd), 16'h1);
    test_txd = 1'b0; idle(2);
    chk("R10", 16'(xcvr_txd), 16'h0);
    set_bus(1'b0, 5);
    chk("R10", 16'(test_rxd), 16'h0);
    chk("R10", 16'(uart_rx), 16'h1);
    set_bus(1'b1, 5);
    wr(3'd0, 16'h0000); idle(2);
    chk("R10", 16'(test_rxd), 16'h1);
    chk("R10", 16'(xcvr_txd), 16'h0);
    uart_txd = 1'b1; idle(2);
    chk("R10", 16'(xcvr_txd), 16'h1);
    idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule